// File: doc/BRIEF.md
# PWM-Synchronized A/D Trigger Generator

This block watches the running count of a PWM time base and produces a one-clock trigger pulse for an A/D converter at a chosen point in the PWM period. Software writes a compare value. Each time the time-base count reaches that value, the block sees a match event. When the time base runs in continuous up/down mode, a phase-select bit limits the events that count to either the up-counting half or the down-counting half of the period. In all other modes the phase-select bit has no effect.

Qualifying matches feed a 4-bit postscaler, so a trigger can be issued on every match or on as few as one match in sixteen. This lets the sampling instant sit close to the duty-cycle update point. Configuration arrives over a small write-enable bus with two locations: the compare value, and a control word that holds the ratio and the phase select. Writing the compare location restarts the postscaler.

Top module: `pwm_adc_trig`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the trigger output, the postscaler count, the compare value, the ratio and the phase select. In the cycle after reset, `adc_trig` is 0.
- R2: A match event occurs on the first cycle in which `tb_count` equals the stored compare value. If the count stays at that value on later cycles, no further events occur until the count has differed from it for at least one cycle.
- R3: When `tb_updown_mode` is 1, the phase select `wr_data[4]` at address 1 decides which matches qualify. A value of 0 accepts matches only while `tb_dir_down` is 0 (counting up). A value of 1 accepts matches only while `tb_dir_down` is 1.
- R4: When `tb_updown_mode` is 0, every match qualifies, whatever the phase select and `tb_dir_down`.
- R5: The ratio field `wr_data[3:0]` at address 1, with value V, gives one trigger for every V+1 qualifying matches. The trigger is issued on the match that completes the count, and the count then returns to zero.
- R6: `adc_trig` is high for exactly one clock. It rises in the cycle after the edge at which the completing match was present on the inputs.
- R7: A write to address 0 (compare value, `wr_data[9:0]`) clears the postscaler count. A match that is present in the same cycle as that write is discarded.
- R8: A ratio write does not clear the postscaler count. The new ratio applies from the next qualifying match onward. If the accumulated count already reaches or exceeds the new ratio, that next qualifying match triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_count | input | CNT_W (10) | PWM time-base count value |
| tb_dir_down | input | 1 | 1 while the time base counts down |
| tb_updown_mode | input | 1 | 1 when the time base is in continuous up/down mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = compare value, 1 = control word |
| wr_data | input | DATA_W (16) | Write data |
| adc_trig | output | 1 | One-cycle A/D trigger pulse |

## Verification
A compare-register write can land in the same cycle as a qualifying match. The write must win: the match is discarded and the postscaler count is zeroed. Directed sequences place the count on the compare value exactly in the write cycle. Random stimulus also issues compare writes alongside small count ranges, which makes such collisions frequent. A bench reference model decides the trigger timing, and the design's trigger output is compared against it on every cycle, so a match counted in a write cycle shows up as an early trigger.

// File: rtl/pwm_trig_pkg.sv
// Package: shared types for the PWM-synchronized A/D trigger generator.
// Assumes a 4-bit postscaler ratio and a two-location register space.
package pwm_trig_pkg;
    localparam int unsigned RATIO_W = 4;

    typedef enum logic [0:0] {
        SEL_CMP  = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic               phase_down;
        logic [RATIO_W-1:0] ratio;
    } trig_cfg_t;
endpackage

// File: rtl/pwm_trig_regs.sv
// Register file: holds the compare value and the control word.
// Assumes DATA_W covers both CNT_W and the control field bits.
// Emits a one-cycle strobe whenever the compare location is written.
module pwm_trig_regs
    import pwm_trig_pkg::*;
#(
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cmp_val,
    output trig_cfg_t         cfg,
    output logic              cmp_wr
);
    localparam int unsigned PHASE_BIT = RATIO_W;

    // Decode a write aimed at the compare location.
    always_comb begin
        cmp_wr = wr_en && (reg_sel_e'(wr_addr) == SEL_CMP);
    end

    // Capture the compare value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_val <= '0;
        else if (cmp_wr)
            cmp_val <= wr_data[CNT_W-1:0];
    end

    // Capture the ratio and phase select.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL)) begin
            cfg.ratio      <= wr_data[RATIO_W-1:0];
            cfg.phase_down <= wr_data[PHASE_BIT];
        end
    end
endmodule

// File: rtl/pwm_trig_match.sv
// Match qualifier: finds the first cycle where the count equals the compare
// value and applies the up/down phase filter. Assumes the count is synchronous.
// A compare write in the same cycle blocks the event.
module pwm_trig_match #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tb_count,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cmp_wr,
    input  logic             updown_mode,
    input  logic             dir_down,
    input  logic             phase_down,
    output logic             match_ok
);
    logic eq_now;
    logic eq_prev;
    logic phase_ok;

    // Compare the count with the stored value and apply the phase filter.
    always_comb begin
        eq_now   = (tb_count == cmp_val);
        phase_ok = !updown_mode || (dir_down == phase_down);
        match_ok = eq_now && !eq_prev && phase_ok && !cmp_wr;
    end

    // Remember last cycle's equality so a held count gives one event only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eq_prev <= 1'b0;
        else
            eq_prev <= eq_now;
    end
endmodule

// File: rtl/pwm_trig_postscale.sv
// Postscaler: counts qualifying matches and fires a registered one-cycle
// trigger on the match that reaches the ratio. Assumes clr has priority.
module pwm_trig_postscale #(
    parameter int unsigned RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          match_ok,
    input  logic          clr,
    input  logic [RW-1:0] ratio,
    output logic [RW-1:0] cnt,
    output logic          trig
);
    // Advance or restart the count and generate the trigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            trig <= 1'b0;
        end else if (clr) begin
            cnt  <= '0;
            trig <= 1'b0;
        end else if (match_ok) begin
            if (cnt >= ratio) begin
                cnt  <= '0;
                trig <= 1'b1;
            end else begin
                cnt  <= cnt + 1'b1;
                trig <= 1'b0;
            end
        end else begin
            trig <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_adc_trig.sv
// Top: A/D trigger generator synchronized to a PWM time base.
// Assumes tb_count, tb_dir_down and tb_updown_mode share clk.
module pwm_adc_trig
    import pwm_trig_pkg::*;
#(
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tb_count,
    input  logic              tb_dir_down,
    input  logic              tb_updown_mode,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              adc_trig
);
    logic [CNT_W-1:0]   cmp_val;
    trig_cfg_t          cfg;
    logic               cmp_wr;
    logic               match_ok;
    logic [RATIO_W-1:0] ps_cnt;
    logic               phase_down;

    // Expose the phase select as its own net for the checker.
    always_comb phase_down = cfg.phase_down;

    pwm_trig_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmp_val(cmp_val), .cfg(cfg), .cmp_wr(cmp_wr)
    );

    pwm_trig_match #(.CNT_W(CNT_W)) u_match (
        .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .cmp_val(cmp_val),
        .cmp_wr(cmp_wr), .updown_mode(tb_updown_mode), .dir_down(tb_dir_down),
        .phase_down(phase_down), .match_ok(match_ok)
    );

    pwm_trig_postscale #(.RW(RATIO_W)) u_post (
        .clk(clk), .rst_n(rst_n), .match_ok(match_ok), .clr(cmp_wr),
        .ratio(cfg.ratio), .cnt(ps_cnt), .trig(adc_trig)
    );
endmodule

// File: rtl/pwm_adc_trig_chk.sv
// Checker: temporal properties for pwm_adc_trig, attached with bind.
module pwm_adc_trig_chk #(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned RW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_trig,
    input logic [RW-1:0]    ps_cnt,
    input logic [CNT_W-1:0] tb_count,
    input logic [CNT_W-1:0] cmp_val,
    input logic             tb_updown_mode,
    input logic             tb_dir_down,
    input logic             phase_down,
    input logic             cmp_wr
);
    logic seen;

    // Mark that one full cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!adc_trig && ps_cnt == '0));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |=> !adc_trig);

    a_r5_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> ps_cnt == '0);

    a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> (ps_cnt == '0 && !adc_trig));

    a_r2_held_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && tb_count == cmp_val && $past(tb_count) == $past(cmp_val))
        |=> !adc_trig);

    a_r3_phase_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && adc_trig) |->
        $past(!tb_updown_mode || (tb_dir_down == phase_down)));
endmodule

bind pwm_adc_trig pwm_adc_trig_chk #(.CNT_W(CNT_W), .RW(pwm_trig_pkg::RATIO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_trig(adc_trig), .ps_cnt(ps_cnt),
    .tb_count(tb_count), .cmp_val(cmp_val), .tb_updown_mode(tb_updown_mode),
    .tb_dir_down(tb_dir_down), .phase_down(phase_down), .cmp_wr(cmp_wr)
);

// File: tb/sim_pwm_adc_trig.sv
module sim_pwm_adc_trig;
    localparam int CW = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] tb_count = '0;
    logic          tb_dir_down = 1'b0;
    logic          tb_updown_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          adc_trig;

    int checks = 0;
    int errors = 0;

    // Reference state, built from the requirements.
    logic [CW-1:0] m_cmp;
    logic [3:0]    m_ratio;
    logic          m_phase;
    logic          m_eqq;
    logic [4:0]    m_cnt;

    always #4 clk = ~clk;

    pwm_adc_trig #(.CNT_W(CW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .tb_dir_down(tb_dir_down),
        .tb_updown_mode(tb_updown_mode), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .adc_trig(adc_trig)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: adc_trig=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_cmp = '0; m_ratio = '0; m_phase = 1'b0; m_eqq = 1'b0; m_cnt = '0;
    endfunction

    // Expected trigger for the next cycle; updates the reference state.
    function automatic logic model_step(input logic [CW-1:0] c, input logic dn,
                                        input logic ud, input logic we,
                                        input logic a, input logic [DW-1:0] d);
        logic eq, cwr, q, t;
        eq  = (c == m_cmp);
        cwr = we && (a == 1'b0);
        q   = eq && !m_eqq && (!ud || dn == m_phase) && !cwr;
        t   = 1'b0;
        if (cwr) m_cnt = '0;
        else if (q) begin
            if (m_cnt >= {1'b0, m_ratio}) begin m_cnt = '0; t = 1'b1; end
            else m_cnt = m_cnt + 5'd1;
        end
        m_eqq = eq;
        if (cwr) m_cmp = d[CW-1:0];
        if (we && a) begin m_ratio = d[3:0]; m_phase = d[4]; end
        return t;
    endfunction

    // Drive one cycle of inputs, then compare adc_trig with the model.
    task automatic cyc(input int c, input logic dn, input logic ud, input logic we,
                       input logic a, input int d, input string req);
        logic exp;
        tb_count = c[CW-1:0]; tb_dir_down = dn; tb_updown_mode = ud;
        wr_en = we; wr_addr = a; wr_data = d[DW-1:0];
        exp = model_step(c[CW-1:0], dn, ud, we, a, d[DW-1:0]);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check(adc_trig, exp, req);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        @(posedge clk); @(negedge clk);
        check(adc_trig, 1'b0, "R1 reset");
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 0, "R1 after reset");

        // R5 ratio 1:1, plain mode
        cyc(9, 0, 0, 1, 0, 5, "R7 compare write");
        cyc(4, 0, 0, 0, 0, 0, "R5 no match");
        cyc(5, 0, 0, 0, 0, 0, "R5 first match triggers");
        cyc(5, 0, 0, 0, 0, 0, "R6 pulse ends");
        // R2 held count gives no repeat
        cyc(5, 0, 0, 0, 0, 0, "R2 hold");
        cyc(5, 0, 0, 0, 0, 0, "R2 hold again");
        // R3 up/down, phase up
        cyc(4, 1, 1, 0, 0, 0, "R3 leave");
        cyc(5, 1, 1, 0, 0, 0, "R3 down rejected");
        cyc(4, 0, 1, 0, 0, 0, "R3 leave");
        cyc(5, 0, 1, 0, 0, 0, "R3 up accepted");
        // R3 phase down selected
        cyc(4, 0, 1, 1, 1, 16, "R3 select down");
        cyc(5, 0, 1, 0, 0, 0, "R3 up rejected");
        cyc(4, 1, 1, 0, 0, 0, "R3 leave");
        cyc(5, 1, 1, 0, 0, 0, "R3 down accepted");
        // R4 phase ignored outside up/down mode
        cyc(4, 0, 0, 0, 0, 0, "R4 leave");
        cyc(5, 0, 0, 0, 0, 0, "R4 up accepted");
        cyc(4, 1, 0, 0, 0, 0, "R4 leave");
        cyc(5, 1, 0, 0, 0, 0, "R4 down accepted");
        // R5 ratio 1:3 and R7 write collision
        cyc(4, 0, 0, 1, 1, 2, "R5 ratio 3");
        cyc(5, 0, 0, 0, 0, 0, "R5 match one");
        cyc(4, 0, 0, 0, 0, 0, "R5 leave");
        cyc(5, 0, 0, 0, 0, 0, "R5 match two");
        cyc(4, 0, 0, 0, 0, 0, "R7 leave");
        cyc(5, 0, 0, 1, 0, 5, "R7 match in write cycle");
        cyc(4, 0, 0, 0, 0, 0, "R7 leave");
        cyc(5, 0, 0, 0, 0, 0, "R7 count restarted");
        cyc(4, 0, 0, 0, 0, 0, "R7 leave");
        cyc(5, 0, 0, 0, 0, 0, "R7 second");
        cyc(4, 0, 0, 0, 0, 0, "R7 leave");
        cyc(5, 0, 0, 0, 0, 0, "R7 third triggers");
        // R8 ratio change keeps count
        cyc(4, 0, 0, 0, 0, 0, "R8 leave");
        cyc(5, 0, 0, 0, 0, 0, "R8 one");
        cyc(4, 0, 0, 0, 0, 0, "R8 leave");
        cyc(5, 0, 0, 0, 0, 0, "R8 two");
        cyc(4, 0, 0, 1, 1, 0, "R8 ratio to 1:1");
        cyc(5, 0, 0, 0, 0, 0, "R8 next match triggers");
        cyc(4, 0, 0, 1, 1, 5, "R8 ratio 1:6");
        cyc(5, 0, 0, 0, 0, 0, "R8 one of six");
        cyc(4, 0, 0, 1, 1, 1, "R8 ratio to 1:2");
        cyc(5, 0, 0, 0, 0, 0, "R8 count kept, triggers");

        // Random stimulus with frequent write collisions
        for (int i = 0; i < 4000; i++) begin
            int r, c;
            logic we, a;
            r  = int'($urandom_range(0, 19));
            c  = int'($urandom_range(0, 7));
            we = (r < 2);
            a  = (r == 1);
            cyc(c, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), we, a,
                a ? int'($urandom_range(0, 31)) : int'($urandom_range(0, 7)),
                "R5 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule